// File: doc/BRIEF.md
# Asynchronous Bus Read Responder with Wait-State Ready

This block sits on the processor side of a video capture path and answers reads that the host issues on its asynchronous external-memory interface. It runs on the host's peripheral clock. A read access is in progress while the active-low select, output-enable and read-enable strobes are all low. If no buffered word is ready, the block holds the host in an extended access by keeping its ready output low. Once the head word of the upstream buffer has been latched onto the 32-bit data bus, it raises ready for exactly one cycle. The host captures the data one cycle after it samples ready high, then releases its read strobe. The word is consumed on that release.

The upstream buffer is reached through a valid/ready stream port. `src_valid` means a head word is present on `src_data`. `src_ready` is the block's acceptance, and a word leaves the buffer on any clock edge where both are high. The block never raises `src_ready` before it has granted the access. It raises it at most once per read strobe, so buffer back-pressure appears to the host only as wait states. The host reads in bursts of eight back-to-back accesses with short gaps between bursts and a longer gap between transfers. The block tracks the position of each read within its burst and keeps a running total of words delivered.

Top module: `async_read_responder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `rdy`, `src_ready`, `proto_err` and `burst_end` are low and `word_count` is 0.
- R2: `bus_oe` is high exactly while `sel_n` and `oe_n` are both low, whatever the state of `rd_n`.
- R3: When an access is seen at a clock edge with `src_valid` high, `rdy` is high for exactly the following cycle. From that cycle on, `bus_data` holds the `src_data` value sampled at that edge until the next grant.
- R4: During an access with `src_valid` low, `rdy` stays low. The first edge that sees `src_valid` high while the access is still held grants the access as in R3.
- R5: After a grant, `src_ready` is high in each cycle where `rd_n` is high and the access has not yet been closed. The first such clock edge closes the access, so one strobe consumes at most one word.
- R6: If the access ends (any strobe high) before a grant, `proto_err` is high for the one cycle after that edge, no word is consumed and `word_count` does not change.
- R7: `word_count` increases by one in the cycle after each edge where `src_valid` and `src_ready` are both high, and wraps at its width.
- R8: `burst_end` is high for the one cycle after the edge that consumes the 8th, 16th, 24th and so on word since reset.
- R9: A transfer of four bursts of eight reads, with 9-cycle gaps between bursts and a longer gap after the transfer, delivers every word in buffer order with no loss or repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low memory select from host |
| oe_n | input | 1 | Active-low output enable from host |
| rd_n | input | 1 | Active-low read strobe from host |
| rdy | output | 1 | Access ready to host; low stretches the access |
| bus_data | output | 32 | Read data toward host |
| bus_oe | output | 1 | Drive enable for `bus_data` |
| src_valid | input | 1 | Upstream buffer has a head word |
| src_data | input | 32 | Upstream head word |
| src_ready | output | 1 | Accept head word (pop when `src_valid` also high) |
| proto_err | output | 1 | Pulse: access abandoned before ready |
| burst_end | output | 1 | Pulse: eighth word of a burst consumed |
| word_count | output | 16 | Total words delivered, wrapping |

## Verification
A wrong internal access phase shows up at the ports within one or two cycles. It appears as a ready pulse that lasts too long or comes without data, as `src_ready` asserted outside a granted strobe, or as a missing `proto_err` after an abandoned access. A stale data register shows as the wrong word on `bus_data` in the grant cycle. A miscounted burst position appears as a `burst_end` pulse at a count that is not a multiple of eight. Each of these differences is visible in the cycle after the edge that caused it, and the reference model flags it there.

// File: rtl/arr_pkg.sv
package arr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_GRANT = 2'd2,
    PH_HOLD  = 2'd3
  } rd_phase_t;
endpackage

// File: rtl/arr_wait_fsm.sv
module arr_wait_fsm #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access,
  input  logic              rd_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              rdy,
  output logic [DATA_W-1:0] data_q,
  output logic              src_ready,
  output logic              err
);
  import arr_pkg::*;

  rd_phase_t phase;
  logic      granted;

  assign granted   = (phase == PH_GRANT) || (phase == PH_HOLD);
  assign src_ready = granted && rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      rdy    <= 1'b0;
      err    <= 1'b0;
      data_q <= '0;
    end else begin
      rdy <= 1'b0;
      err <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (access) begin
            if (src_valid) begin
              data_q <= src_data;
              rdy    <= 1'b1;
              phase  <= PH_GRANT;
            end else begin
              phase  <= PH_WAIT;
            end
          end
        end
        PH_WAIT: begin
          if (!access) begin
            err   <= 1'b1;
            phase <= PH_IDLE;
          end else if (src_valid) begin
            data_q <= src_data;
            rdy    <= 1'b1;
            phase  <= PH_GRANT;
          end
        end
        PH_GRANT: phase <= rd_n ? PH_IDLE : PH_HOLD;
        PH_HOLD:  if (rd_n) phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arr_burst_track.sv
module arr_burst_track #(
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic             burst_end,
  output logic [CNT_W-1:0] word_count
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] beat_nxt;
  logic              at_last;

  assign at_last = (beat == LAST_BEAT);

  generate
    if ((1 << BEAT_W) == BURST_LEN) begin : g_pow2
      assign beat_nxt = beat + 1'b1;
    end else begin : g_cmp
      assign beat_nxt = at_last ? '0 : beat + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat       <= '0;
      burst_end  <= 1'b0;
      word_count <= '0;
    end else begin
      burst_end <= take && at_last;
      if (take) begin
        beat       <= beat_nxt;
        word_count <= word_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/async_read_responder.sv
module async_read_responder #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              rd_n,
  output logic              rdy,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              proto_err,
  output logic              burst_end,
  output logic [CNT_W-1:0]  word_count
);
  logic access;
  logic take;

  assign access = !sel_n && !oe_n && !rd_n;
  assign bus_oe = !sel_n && !oe_n;
  assign take   = src_ready && src_valid;

  arr_wait_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .access    (access),
    .rd_n      (rd_n),
    .src_valid (src_valid),
    .src_data  (src_data),
    .rdy       (rdy),
    .data_q    (bus_data),
    .src_ready (src_ready),
    .err       (proto_err)
  );

  arr_burst_track #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .burst_end  (burst_end),
    .word_count (word_count)
  );
endmodule

// File: rtl/async_read_responder_chk.sv
module async_read_responder_chk #(
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rdy,
  input logic             src_valid,
  input logic             src_ready,
  input logic             proto_err,
  input logic             burst_end,
  input logic [CNT_W-1:0] word_count
);
  // R3
  rdy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  // R4
  rdy_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(src_valid));

  // R5
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && src_valid) |=> !src_ready);

  // R6
  err_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $stable(word_count));

  // R8
  burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |-> ((word_count % BURST_LEN) == 0));
endmodule

bind async_read_responder async_read_responder_chk #(
  .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rdy        (rdy),
  .src_valid  (src_valid),
  .src_ready  (src_ready),
  .proto_err  (proto_err),
  .burst_end  (burst_end),
  .word_count (word_count)
);

// File: tb/async_read_responder_tb.sv
`timescale 1ns/1ps
module async_read_responder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, oe_n = 1'b1, rd_n = 1'b1;
  logic        src_valid = 1'b0;
  logic [31:0] src_data = '0;
  logic        rdy, bus_oe, src_ready, proto_err, burst_end;
  logic [31:0] bus_data;
  logic [15:0] word_count;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  async_read_responder u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .oe_n(oe_n), .rd_n(rd_n),
    .rdy(rdy), .bus_data(bus_data), .bus_oe(bus_oe),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .proto_err(proto_err), .burst_end(burst_end), .word_count(word_count)
  );

  // behavioural reference
  logic [31:0] q[$];
  int   ph = 0;           // 0 idle, 1 waiting, 2 ready shown, 3 ready given
  bit   m_rdy, m_err, m_burst;
  logic [31:0] m_data;
  int   m_count, m_beat;

  function automatic bit e_oe();  return !sel_n && !oe_n; endfunction
  function automatic bit e_pop(); return (ph >= 2) && rd_n; endfunction

  always @(posedge clk) begin
    bit acc;
    acc = !sel_n && !oe_n && !rd_n;
    if (!rst_n) begin
      ph = 0; m_rdy = 0; m_err = 0; m_burst = 0; m_data = 0; m_count = 0; m_beat = 0;
    end else begin
      m_err = 0; m_burst = 0;
      if (e_pop()) begin
        if (q.size() > 0) begin
          void'(q.pop_front());
          m_count = (m_count + 1) % 65536;
          m_burst = (m_beat == 7);
          m_beat  = (m_beat + 1) % 8;
        end
        ph = 0; m_rdy = 0;
      end else if (ph == 2) begin
        ph = 3; m_rdy = 0;
      end else if (ph == 0 || ph == 1) begin
        if (!acc) begin
          if (ph == 1) m_err = 1;
          ph = 0;
        end else if (q.size() > 0) begin
          m_data = q[0]; m_rdy = 1; ph = 2;
        end else ph = 1;
      end
    end
    src_valid <= (q.size() > 0);
    src_data  <= (q.size() > 0) ? q[0] : 32'h0;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 bus_oe",     32'(bus_oe),    32'(e_oe()));
    chk("R3/R4 rdy",     32'(rdy),       32'(m_rdy));
    chk("R3 bus_data",   bus_data,       m_data);
    chk("R5 src_ready",  32'(src_ready), 32'(e_pop()));
    chk("R6 proto_err",  32'(proto_err), 32'(m_err));
    chk("R7 word_count", 32'(word_count),32'(m_count));
    chk("R8 burst_end",  32'(burst_end), 32'(m_burst));
  end

  task automatic push(input logic [31:0] w);
    q.push_back(w);
    src_valid = 1'b1;
    src_data  = q[0];
  endtask

  task automatic host_read(input int max_wait);
    int n = 0;
    @(posedge clk); #1; sel_n = 0; oe_n = 0; rd_n = 0;
    forever begin
      @(posedge clk); #1; n++;
      if (rdy || n >= max_wait) break;
    end
    @(posedge clk); #1; sel_n = 1; oe_n = 1; rd_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values while in reset
    chk("R1 rdy", 32'(rdy), 0);
    chk("R1 src_ready", 32'(src_ready), 0);
    chk("R1 proto_err", 32'(proto_err), 0);
    chk("R1 burst_end", 32'(burst_end), 0);
    chk("R1 word_count", 32'(word_count), 0);
    rst_n = 1;

    // R3 R5: words already waiting
    push(32'hA0A0_0001); push(32'hA0A0_0002); push(32'hA0A0_0003);
    repeat (3) host_read(20);

    // R2: output enable without read strobe, then select alone
    @(posedge clk); #1; sel_n = 0; oe_n = 0;
    repeat (3) @(posedge clk);
    #1; oe_n = 1;
    repeat (2) @(posedge clk);
    #1; sel_n = 1;

    // R4: read against an empty buffer, word arrives later
    fork
      host_read(50);
      begin repeat (5) @(posedge clk); #1; push(32'hBEEF_0004); end
    join

    // R6: abandoned access, nothing consumed
    host_read(3);
    repeat (3) @(posedge clk);
    #1;
    chk("R6 count unchanged", 32'(word_count), 4);

    // R8 R9: one transfer of four bursts of eight, then a long gap
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 8; i++) push(32'hC000_0000 + 32'(b * 8 + i));
      for (int i = 0; i < 8; i++) host_read(20);
      repeat (9) @(posedge clk);
    end
    repeat (40) @(posedge clk);
    #1;
    chk("R9 total words", 32'(word_count), 36);
    chk("R9 buffer drained", 32'(q.size()), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule